// File: doc/BRIEF.md
# Configurable Registered Output Macrocell

This block is one output cell that sits after a sum-of-products term. It holds a single rising-edge D flip-flop and two configuration selectors. One selector sends either the registered or the unregistered term to the pad. The other picks active-high or active-low drive.

A shared asynchronous reset term clears the flip-flop at once. A shared preset term sets it on the next rising edge.

The cell also returns a feedback bit to the array. In registered mode the bit comes from the flip-flop. In combinational mode it comes from the pad, so a pad whose output enable is off acts as an extra array input. A single configuration bit drives both the register bypass and the feedback source.

Top module: `sop_macrocell`

## Requirements
- R1: `cfg_mode[1]` picks the path: 0 is registered, 1 is combinational. `cfg_mode[0]` picks the polarity: 1 is active-high, 0 is active-low. All four combinations are legal.
- R2: On every rising edge of `clk` the register loads `sum_in`, unless reset or preset applies. In registered mode `pad_o` shows the register and does not change between edges.
- R3: In combinational mode `pad_o` follows `sum_in` within the same cycle, without waiting for a clock edge.
- R4: In either path, active-low polarity drives `pad_o` as the inverse of the active-high value.
- R5: While `arst_term` is high the register is 0. The clear takes effect as soon as `arst_term` rises, with no clock edge needed.
- R6: When `spre_term` is high at a rising edge, the register becomes 1 on that edge. Between edges `spre_term` has no effect.
- R7: When `arst_term` and `spre_term` are both high, the register stays 0.
- R8: In registered mode `fb_o` equals the stored register bit, whatever the polarity setting.
- R9: In combinational mode `fb_o` equals `pad_i`.
- R10: `pad_oe` equals `oe_term`. With `oe_term` low in combinational mode, an external level on `pad_i` reaches `fb_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Global clock shared by all cells, rising edge |
| arst_term | input | 1 | Shared asynchronous clear term, active high |
| spre_term | input | 1 | Shared synchronous preset term, active high |
| cfg_mode | input | 2 | Bit 1: bypass the register; bit 0: active-high drive |
| sum_in | input | 1 | OR-term from the array |
| oe_term | input | 1 | Output-enable term for the pad |
| pad_i | input | 1 | Level observed on the pad |
| pad_o | output | 1 | Value driven to the pad |
| pad_oe | output | 1 | Pad driver enable |
| fb_o | output | 1 | Feedback bit returned to the array |

## Verification
The properties assume three things about the inputs. First, a reset pulse always spans at least one rising edge. Second, the reset and preset terms change only away from the clock edge. Third, the pad input level is supplied by the surrounding pad logic and stays consistent within a cycle.

The stimulus changes every input a short time after the rising edge. It raises the reset mid-cycle only to show that the clear needs no clock, and then holds the reset across the next edge. The first reset is raised shortly after time zero rather than at it, so the flip-flop sees a real reset edge before any clock.

// File: rtl/omc_pkg.sv
package omc_pkg;

    typedef enum logic [1:0] {
        MODE_REG_LO  = 2'b00,
        MODE_REG_HI  = 2'b01,
        MODE_COMB_LO = 2'b10,
        MODE_COMB_HI = 2'b11
    } omc_mode_e;

    // state held by the cell's flip-flop
    typedef struct packed {
        logic bit_v;
    } omc_state_t;

    function automatic logic mode_bypass(input omc_mode_e m);
        return m[1];
    endfunction

    function automatic logic mode_high(input omc_mode_e m);
        return m[0];
    endfunction

endpackage

// File: rtl/omc_store.sv
module omc_store
    import omc_pkg::*;
(
    input  logic clk,
    input  logic arst,
    input  logic preset,
    input  logic d_in,
    output logic q_out
);
    omc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (preset) begin
            st_d.bit_v = 1'b1;
        end else begin
            st_d.bit_v = d_in;
        end
    end

    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_out = st_q.bit_v;
endmodule

// File: rtl/omc_drive.sv
module omc_drive
    import omc_pkg::*;
(
    input  omc_mode_e mode,
    input  logic      comb_in,
    input  logic      reg_in,
    output logic      drv_out
);
    logic pre_pol;

    always_comb begin
        pre_pol = mode_bypass(mode) ? comb_in : reg_in;
        // polarity applies after the bypass choice, to both paths alike
        drv_out = mode_high(mode) ? pre_pol : ~pre_pol;
    end
endmodule

// File: rtl/omc_return.sv
module omc_return
    import omc_pkg::*;
(
    input  omc_mode_e mode,
    input  logic      pin_in,
    input  logic      reg_in,
    output logic      fb_out
);
    always_comb begin
        // register feedback is taken before the polarity stage
        fb_out = mode_bypass(mode) ? pin_in : reg_in;
    end
endmodule

// File: rtl/sop_macrocell.sv
module sop_macrocell
    import omc_pkg::*;
(
    input  logic       clk,
    input  logic       arst_term,
    input  logic       spre_term,
    input  logic [1:0] cfg_mode,
    input  logic       sum_in,
    input  logic       oe_term,
    input  logic       pad_i,
    output logic       pad_o,
    output logic       pad_oe,
    output logic       fb_o
);
    omc_mode_e mode;
    logic      reg_bit;

    assign mode = omc_mode_e'(cfg_mode);

    omc_store u_store (
        .clk    (clk),
        .arst   (arst_term),
        .preset (spre_term),
        .d_in   (sum_in),
        .q_out  (reg_bit)
    );

    omc_drive u_drive (
        .mode    (mode),
        .comb_in (sum_in),
        .reg_in  (reg_bit),
        .drv_out (pad_o)
    );

    omc_return u_return (
        .mode   (mode),
        .pin_in (pad_i),
        .reg_in (reg_bit),
        .fb_out (fb_o)
    );

    assign pad_oe = oe_term;
endmodule

// File: rtl/sop_macrocell_chk.sv
module sop_macrocell_chk (
    input logic       clk,
    input logic       arst_term,
    input logic       spre_term,
    input logic [1:0] cfg_mode,
    input logic       sum_in,
    input logic       oe_term,
    input logic       pad_i,
    input logic       pad_o,
    input logic       pad_oe,
    input logic       fb_o
);
    // R2
    reg_capture_chk: assert property (@(posedge clk) disable iff (arst_term)
        (!cfg_mode[1] && !$past(arst_term) && !$past(spre_term))
        |-> (pad_o == (cfg_mode[0] ? $past(sum_in) : !$past(sum_in))));

    // R6
    preset_set_chk: assert property (@(posedge clk) disable iff (arst_term)
        (!cfg_mode[1] && $past(spre_term) && !$past(arst_term)) |-> fb_o);

    // R3
    comb_high_chk: assert property (@(posedge clk) disable iff (arst_term)
        (cfg_mode == 2'b11) |-> (pad_o == sum_in));

    // R4
    comb_low_chk: assert property (@(posedge clk) disable iff (arst_term)
        (cfg_mode == 2'b10) |-> (pad_o != sum_in));

    // R9
    fb_pin_chk: assert property (@(posedge clk) disable iff (arst_term)
        cfg_mode[1] |-> (fb_o == pad_i));

    // R8
    fb_reg_chk: assert property (@(posedge clk) disable iff (arst_term)
        !cfg_mode[1] |-> (fb_o == (cfg_mode[0] ? pad_o : !pad_o)));

    // R5
    reset_clear_chk: assert property (@(posedge clk)
        (arst_term && $past(arst_term) && !cfg_mode[1]) |-> !fb_o);

    // R7
    reset_wins_chk: assert property (@(posedge clk)
        (arst_term && spre_term && $past(arst_term) && !cfg_mode[1])
        |-> (pad_o == !cfg_mode[0]));
endmodule

bind sop_macrocell sop_macrocell_chk u_chk (
    .clk       (clk),
    .arst_term (arst_term),
    .spre_term (spre_term),
    .cfg_mode  (cfg_mode),
    .sum_in    (sum_in),
    .oe_term   (oe_term),
    .pad_i     (pad_i),
    .pad_o     (pad_o),
    .pad_oe    (pad_oe),
    .fb_o      (fb_o)
);

// File: tb/sop_macrocell_test.sv
module sop_macrocell_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       arst_term = 1'b0;
    logic       spre_term = 1'b0;
    logic [1:0] cfg_mode = 2'b00;
    logic       sum_in = 1'b0;
    logic       oe_term = 1'b0;
    logic       pad_i = 1'b0;
    logic       pad_o, pad_oe, fb_o;

    int n_vec = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sop_macrocell uut (
        .clk(clk), .arst_term(arst_term), .spre_term(spre_term),
        .cfg_mode(cfg_mode), .sum_in(sum_in), .oe_term(oe_term),
        .pad_i(pad_i), .pad_o(pad_o), .pad_oe(pad_oe), .fb_o(fb_o)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // rising edge, then settle one unit past it
    task automatic edge_settle();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        #2 arst_term = 1'b1;
        #1;
        cfg_mode = 2'b00;
        #1;
        chk("R5 reset fb", fb_o, 1'b0);
        chk("R1 reg active-low pad during reset", pad_o, 1'b1);
        edge_settle();
        edge_settle();
        arst_term = 1'b0;
        #1;
    endtask

    task automatic t_registered(input logic hi);
        cfg_mode = {1'b0, hi};
        for (int i = 0; i < 4; i++) begin
            logic v;
            v = logic'((i % 3) == 1 || i == 3);
            sum_in = v;
            edge_settle();
            chk("R2 capture", pad_o, hi ? v : ~v);
            chk("R8 reg feedback", fb_o, v);
            sum_in = ~v;
            #1;
            chk("R2 stable between edges", pad_o, hi ? v : ~v);
        end
    endtask

    task automatic t_comb(input logic hi);
        cfg_mode = {1'b1, hi};
        for (int i = 0; i < 2; i++) begin
            logic v;
            v = logic'(i);
            sum_in = v;
            #1;
            chk(hi ? "R3 comb follow" : "R4 comb inverted", pad_o, hi ? v : ~v);
        end
        edge_settle();
    endtask

    task automatic t_preset();
        cfg_mode = 2'b01;
        sum_in = 1'b0;
        edge_settle();
        chk("R2 zero loaded", fb_o, 1'b0);
        spre_term = 1'b1;
        #1;
        chk("R6 no effect before edge", fb_o, 1'b0);
        edge_settle();
        chk("R6 preset on edge", fb_o, 1'b1);
        chk("R6 preset pad", pad_o, 1'b1);
        spre_term = 1'b0;
        edge_settle();
        chk("R2 back to sum", fb_o, 1'b0);
    endtask

    task automatic t_reset_async_and_wins();
        cfg_mode = 2'b00;
        sum_in = 1'b1;
        edge_settle();
        chk("R2 one loaded", fb_o, 1'b1);
        #2 arst_term = 1'b1;
        #1;
        chk("R5 clear without edge", fb_o, 1'b0);
        chk("R5 pad active-low", pad_o, 1'b1);
        spre_term = 1'b1;
        edge_settle();
        chk("R7 reset over preset", fb_o, 1'b0);
        arst_term = 1'b0;
        spre_term = 1'b0;
        sum_in = 1'b0;
        edge_settle();
    endtask

    task automatic t_pin_input();
        cfg_mode = 2'b10;
        oe_term = 1'b0;
        #1;
        chk("R10 oe low", pad_oe, 1'b0);
        pad_i = 1'b1;
        #1;
        chk("R10 pin as input", fb_o, 1'b1);
        chk("R9 pin feedback", fb_o, pad_i);
        pad_i = 1'b0;
        #1;
        chk("R9 pin feedback low", fb_o, 1'b0);
        oe_term = 1'b1;
        #1;
        chk("R10 oe high", pad_oe, 1'b1);
        edge_settle();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog all requirements actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_registered(1'b1);
        t_registered(1'b0);
        t_comb(1'b1);
        t_comb(1'b0);
        t_preset();
        t_reset_async_and_wins();
        t_pin_input();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule